// File: doc/BRIEF.md
# Delay-Line Sampling Phase Programmer

This block moves a delay-line clock generator to a new sampling phase by stepping through a fixed series of read-modify-write cycles on the generator's 32-bit control register. The block takes a single-cycle request with a 4-bit phase index. It converts the index to Gray code and disables the generated clock output. It then waits until the output reports itself off, loads the new phase, and re-enables the output. After the output reports itself on again, the block hands clock-data recovery back to automatic mode.

The register is reached over a plain register bus: a valid/ready handshake, a write flag, write data and read data, all aimed at one register. Every field the block does not own keeps its previous value. Each wait polls the output-enable bit at most a fixed number of times, one microsecond apart, with the microsecond derived from the clock frequency parameter. When a wait runs out, the sequence stops and the block reports an error.

Top module: `dll_phase_seq`

## Requirements
- R1: After reset, busy, done and err are low and no bus transfer is requested.
- R2: The first write of a sequence clears bit 17 (recovery enable) and bit 18 (clock output enable). It sets bit 19 (external phase select) and bit 16 (delay-line enable). All other bits keep the value read just before.
- R3: After the first write, the block reads the register until bit 18 reads 0. It makes at most POLLS reads, with at least CLK_HZ/1e6 cycles between reads. If bit 18 is still 1 on the last read, err is raised and no further write is issued.
- R4: The second write places the Gray code of the phase index (p xor p>>1, so 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8) in bits 23:20. Every other bit keeps its value.
- R5: The third write sets bit 18 and changes no other bit.
- R6: After the third write, the block reads until bit 18 reads 1, with the same limit and spacing as R3. On timeout, err is raised and the final write is not issued.
- R7: The fourth and last write sets bit 17 and clears bit 19. A successful sequence issues exactly four writes and then pulses done for one cycle, with busy low.
- R8: A request that arrives while busy is ignored.
- R9: err stays high until the next accepted request, which clears it.
- R10: A bus request with ready low keeps valid, write and write data unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a phase change (accepted when idle) |
| phase | input | 4 | Binary phase index 0..15 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on success |
| err | output | 1 | Poll timeout; held until next request |
| bus_valid | output | 1 | Register transfer request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Transfer accepted this cycle |
| bus_rdata | input | 32 | Read data, valid when ready on a read |

## Verification
A corrupted copy of the register would show up at the bus as a wrong write word. Each of the four writes is compared in full against a value predicted from the preset register contents, so such a fault is reported by the end of the same sequence. A wrong poll count or poll interval shows in the number of reads and in the elapsed cycles of a forced timeout, about ten thousand cycles later. A sequencing fault appears as a write count other than 1, 3 or 4, or as done and err in the wrong combination.

// File: rtl/dll_phase_seq.sv
module dll_phase_seq #(
  parameter int CLK_HZ = 200_000_000,
  parameter int POLLS  = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [3:0]  phase,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        bus_valid,
  output logic        bus_write,
  output logic [31:0] bus_wdata,
  input  logic        bus_ready,
  input  logic [31:0] bus_rdata
);
  localparam int US_CYC = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int UW = $clog2(US_CYC + 1);
  localparam int PW = $clog2(POLLS + 1);
  localparam logic [31:0] EN_B  = 32'h1 << 16;
  localparam logic [31:0] REC_B = 32'h1 << 17;
  localparam logic [31:0] OUT_B = 32'h1 << 18;
  localparam logic [31:0] EXT_B = 32'h1 << 19;
  localparam logic [31:0] FLD_M = 32'hF << 20;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_A, S_WR_A, S_POLL_LO, S_GAP_LO, S_WR_B,
    S_RD_C, S_WR_C, S_POLL_HI, S_GAP_HI, S_WR_D
  } st_t;

  st_t st;
  logic [31:0] shadow;
  logic [3:0]  gray_q;
  logic [PW-1:0] polls;
  logic [UW-1:0] gap;

  wire xfer = bus_valid && bus_ready;
  wire [PW-1:0] polls_nx = polls + 1'b1;

  assign busy = (st != S_IDLE);
  assign bus_valid = st inside {S_RD_A, S_WR_A, S_POLL_LO, S_WR_B, S_RD_C, S_WR_C, S_POLL_HI, S_WR_D};
  assign bus_write = st inside {S_WR_A, S_WR_B, S_WR_C, S_WR_D};

  always_comb begin
    case (st)
      S_WR_A:  bus_wdata = (shadow & ~(REC_B | OUT_B)) | EXT_B | EN_B;
      S_WR_B:  bus_wdata = (shadow & ~FLD_M) | ({28'd0, gray_q} << 20);
      S_WR_C:  bus_wdata = shadow | OUT_B;
      S_WR_D:  bus_wdata = (shadow | REC_B) & ~EXT_B;
      default: bus_wdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; shadow <= '0; gray_q <= '0; polls <= '0; gap <= '0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (xfer && !bus_write) shadow <= bus_rdata;
      case (st)
        S_IDLE: if (req) begin
          st <= S_RD_A; err <= 1'b0; gray_q <= phase ^ (phase >> 1);
        end
        S_RD_A: if (xfer) st <= S_WR_A;
        S_WR_A: if (xfer) begin st <= S_POLL_LO; polls <= '0; end
        S_POLL_LO, S_POLL_HI: if (xfer) begin
          polls <= polls_nx;
          gap <= '0;
          if (bus_rdata[18] == (st == S_POLL_HI))
            st <= (st == S_POLL_HI) ? S_WR_D : S_WR_B;
          else if (polls_nx == PW'(POLLS)) begin
            st <= S_IDLE; err <= 1'b1;
          end else
            st <= (st == S_POLL_HI) ? S_GAP_HI : S_GAP_LO;
        end
        S_GAP_LO, S_GAP_HI:
          if (gap == UW'(US_CYC - 1)) st <= (st == S_GAP_HI) ? S_POLL_HI : S_POLL_LO;
          else gap <= gap + 1'b1;
        S_WR_B: if (xfer) st <= S_RD_C;
        S_RD_C: if (xfer) st <= S_WR_C;
        S_WR_C: if (xfer) begin st <= S_POLL_HI; polls <= '0; end
        S_WR_D: if (xfer) begin st <= S_IDLE; done <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_write) && $stable(bus_wdata));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && !err);
  // R3
  poll_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) polls <= PW'(POLLS));
  // R8
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(req));
  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) err && !busy && !req |=> err);
endmodule

// File: tb/dll_phase_seq_bench.sv
module dll_phase_seq_bench;
  logic clk = 0, rst_n = 0, req = 0;
  logic [3:0] phase = 0;
  logic busy, done, err, bus_valid, bus_write, bus_ready;
  logic [31:0] bus_wdata, bus_rdata;
  always #2.5 clk = ~clk;

  dll_phase_seq u_dll_phase_seq (.*);

  logic [31:0] cfg = 0;
  logic stat = 0;
  int mode = 0, dly = 0, lag = 0;
  int nwr = 0, nrd = 0, cyc = 0;
  logic [31:0] wlog [8];
  logic stall = 0;
  int npass = 0, nfail = 0;

  assign bus_ready = ~stall;
  assign bus_rdata = {cfg[31:19], stat, cfg[17:0]};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    stall <= ~stall;
    if (bus_valid && bus_ready) begin
      if (bus_write) begin
        cfg <= bus_wdata;
        if (nwr < 8) wlog[nwr] <= bus_wdata;
        nwr <= nwr + 1;
      end else nrd <= nrd + 1;
    end
    if (mode == 1) stat <= 1'b1;
    else if (mode == 2) stat <= 1'b0;
    else if (stat != cfg[18]) begin
      if (lag >= dly) begin stat <= cfg[18]; lag <= 0; end
      else lag <= lag + 1;
    end else lag <= 0;
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    if (ok) npass++;
    else begin nfail++; $display("FAIL %s actual=%h expected=%h", r, act, exp); end
  endtask

  function automatic logic [31:0] w1(input logic [31:0] v);
    return (v & ~32'h0006_0000) | 32'h0009_0000;
  endfunction
  function automatic logic [31:0] w2(input logic [31:0] v, input logic [3:0] p);
    logic [3:0] g = p ^ (p >> 1);
    return (v & ~32'h00F0_0000) | ({28'd0, g} << 20);
  endfunction

  task automatic start(input logic [31:0] preset, input int m, input logic [3:0] p);
    @(negedge clk);
    cfg = preset; stat = preset[18]; mode = m; lag = 0;
    nwr = 0; nrd = 0; phase = p; req = 1;
    @(negedge clk); req = 0;
  endtask

  task automatic wait_end(output int took);
    int t0 = cyc;
    while (!(done || err) && cyc - t0 < 30000) @(negedge clk);
    took = cyc - t0;
    if (cyc - t0 >= 30000) chk(0, "watchdog", cyc - t0, 0);
  endtask

  task automatic t_ok(input logic [31:0] preset, input logic [3:0] p);
    int took;
    logic [31:0] e1, e2, e3, e4;
    e1 = w1(preset); e2 = w2(e1, p); e3 = e2 | 32'h0004_0000;
    e4 = (e3 | 32'h0002_0000) & ~32'h0008_0000;
    start(preset, 0, p);
    wait_end(took);
    chk(done && !busy && !err, "R7 done", {done, busy, err}, 3'b100);
    chk(nwr == 4, "R7 writes", nwr, 4);
    chk(wlog[0] == e1, "R2 first write", wlog[0], e1);
    chk(wlog[1] == e2, "R4 gray field", wlog[1], e2);
    chk(wlog[2] == e3, "R5 output on", wlog[2], e3);
    chk(wlog[3] == e4, "R7 final write", wlog[3], e4);
    @(negedge clk);
    chk(!done, "R7 pulse width", done, 0);
  endtask

  task automatic t_to_lo;
    int took;
    start(32'h0004_0000, 1, 4'd3);
    wait_end(took);
    chk(err && !done && !busy, "R3 timeout err", {err, done, busy}, 3'b100);
    chk(nwr == 1, "R3 no write after timeout", nwr, 1);
    chk(nrd == 51, "R3 poll count", nrd, 51);
    chk(took >= 49 * 200, "R3 poll spacing", took, 49 * 200);
    repeat (20) @(negedge clk);
    chk(err, "R9 err held", err, 1);
    chk(nwr == 1, "R3 stays stopped", nwr, 1);
  endtask

  task automatic t_to_hi;
    int took;
    start(32'h0000_0000, 2, 4'd9);
    @(negedge clk);
    chk(!err, "R9 err cleared on request", err, 0);
    wait_end(took);
    chk(err && !done, "R6 timeout err", {err, done}, 2'b10);
    chk(nwr == 3, "R6 no final write", nwr, 3);
    chk(nrd == 53, "R6 poll count", nrd, 53);
  endtask

  task automatic t_busy_req;
    int took;
    start(32'h0000_0000, 0, 4'd6);
    repeat (3) @(negedge clk);
    phase = 4'd1; req = 1;
    @(negedge clk); req = 0;
    wait_end(took);
    chk(wlog[1][23:20] == 4'h5, "R8 field from first request", wlog[1][23:20], 4'h5);
    repeat (10) @(negedge clk);
    chk(!busy && nwr == 4, "R8 no second run", nwr, 4);
  endtask

  initial begin
    dly = 300;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !bus_valid, "R1 reset", {busy, done, err, bus_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_valid, "R1 idle after reset", {busy, bus_valid}, 0);
    t_ok(32'h0000_0000, 4'd0);
    t_ok(32'hA5A5_A5A5, 4'd5);
    t_ok(32'hFFFF_FFFF, 4'd15);
    t_ok(32'h1234_5678, 4'd10);
    t_to_lo();
    t_to_hi();
    t_busy_req();
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  end

  initial begin
    #950000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  end
endmodule